// File: doc/BRIEF.md
# Command Buffer Header Parser

This block sits at the head of a graphics command pipeline. It takes 32-bit words from a circular command buffer over a valid/ready stream, treats the first word of each packet as a header, and hands out the words that follow it. A header either starts a register-update packet or a data packet. A register-update packet carries a sparse write-enable mask: only the words for set mask bits are present in the stream, and the parser sends each of them out as a register write to the slot given by its bit position. A data packet carries a routing type and a word count. The parser forwards that many words to one of four sinks, each tagged with its position in the packet. For the pattern sink, that position selects pattern colour register 2 plus the position.

Two header flags control flow. The stall flag holds the packet's payload until the downstream pipeline reports idle. The wrap flag sends the read pointer back to the start of the buffer once the packet has been consumed. Routing types with the top bit set are reserved. Such a packet raises an error strobe, and its counted words are drained without being forwarded.

Header layout: bit 31 is the kind (1 = data packet, 0 = register update), bit 30 is wrap and bit 29 is stall. For data packets, bits 28:26 are the routing type and bits COUNT_W-1:0 are the word count. For register updates, bits MASK_W-1:0 are the write-enable mask.

Top module: `cmdParser`

## Requirements
- R1: In a register-update packet, the set mask bits are served in ascending bit order. Each accepted payload word raises regWrValid with regWrIdx equal to the bit position and regWrData equal to the word.
- R2: Clear mask bits take no word from the stream. A packet yields exactly as many register writes as it has set bits. A mask of zero makes the next word a header.
- R3: A data packet whose type is 0 to 3 forwards exactly count words. Each word raises dataValid with dataDest equal to type[1:0] (0 primary source, 1 auxiliary channel, 2 pattern colours, 3 lookup/pattern space) and dataSeq counting 0, 1, 2 and so on.
- R4: A data packet with a count of zero produces no output, and the next word is a header.
- R5: A header with type bit 28 set raises errReserved in its accept cycle. Its count words are then consumed with no output, and parsing resumes at the following header.
- R6: After a header with bit 29 set is accepted, inReady stays low until pipeIdle is high, and only then is the payload accepted. A header without bit 29 never waits on pipeIdle.
- R7: rdPtr advances by one for every accepted word, modulo 2^PTR_W.
- R8: When the last word of a packet with bit 30 set is accepted, rdPtr becomes 0. For an empty packet, that last word is the header itself.
- R9: After reset, inReady is high, rdPtr is 0 and no output strobe is active.
- R10: regWrValid and dataValid are never high together, and neither is high without inValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inWord | input | 32 | Command word from the buffer |
| inValid | input | 1 | inWord is valid |
| inReady | output | 1 | Parser accepts inWord this cycle |
| pipeIdle | input | 1 | Downstream pipeline is empty |
| regWrValid | output | 1 | Register write strobe |
| regWrIdx | output | $clog2(MASK_W) | Register slot being written |
| regWrData | output | 32 | Register write data |
| dataValid | output | 1 | Data word strobe |
| dataDest | output | 2 | Destination sink of the data word |
| dataSeq | output | COUNT_W | Position of the word in its packet |
| dataWord | output | 32 | Forwarded data word |
| errReserved | output | 1 | Reserved routing type seen in a header |
| rdPtr | output | PTR_W | Read pointer into the command buffer |

## Verification
The assertions check on every cycle the properties that hold locally. The two output strobes never overlap, a reserved packet stays silent while draining, the input is blocked during a stall with the pipeline busy, and each register write hits a live mask bit and clears exactly one. They also check that the pointer steps by one or returns to zero at a wrapping packet end. Only the bench scenarios can show properties that span a whole packet. These are that every mask value yields the right number and order of writes, that each type and count forwards the right run of words to the right sink, that empty and reserved packets return cleanly to header parsing, and that the pointer stays in step over long mixed streams.

// File: rtl/cmdParserPkg.sv
package cmdParserPkg;
  localparam int HDR_KIND_BIT  = 31;
  localparam int HDR_WRAP_BIT  = 30;
  localparam int HDR_STALL_BIT = 29;
  localparam int HDR_TYPE_LSB  = 26;
  localparam int HDR_TYPE_W    = 3;
  localparam int WORD_W        = 32;

  typedef enum logic [2:0] {
    ST_HDR, ST_WAIT, ST_REGS, ST_DATA, ST_SKIP
  } parseState_t;

  typedef struct packed {
    logic accept;
    logic loadHdr;
    logic consumeReg;
    logic consumeData;
    logic endPkt;
  } ctrlStrb_t;

  typedef struct packed {
    logic hdrIsData;
    logic hdrStall;
    logic hdrReserved;
    logic hdrEmpty;
    logic regLast;
    logic dataLast;
  } pathStat_t;
endpackage

// File: rtl/cmdParserPath.sv
module cmdParserPath
  import cmdParserPkg::*;
#(
  parameter int MASK_W  = 16,
  parameter int COUNT_W = 12,
  parameter int PTR_W   = 10,
  localparam int IDX_W  = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WORD_W-1:0]   inWord,
  input  ctrlStrb_t           strb,
  output pathStat_t           stat,
  output logic [IDX_W-1:0]    regWrIdx,
  output logic [1:0]          dataDest,
  output logic [COUNT_W-1:0]  dataSeq,
  output logic [PTR_W-1:0]    rdPtr
);
  logic [MASK_W-1:0]  maskLeft;
  logic [MASK_W-1:0]  lowOne;
  logic [COUNT_W-1:0] cntLeft;
  logic [HDR_TYPE_W-1:0] typeReg;
  logic               wrapFlag;
  logic               wrapNow;
  logic [HDR_TYPE_W-1:0] hdrType;

  initial begin
    if (MASK_W > HDR_TYPE_LSB || COUNT_W > HDR_TYPE_LSB)
      $error("field width overlaps header flags");
  end

  assign hdrType          = inWord[HDR_TYPE_LSB +: HDR_TYPE_W];
  assign stat.hdrIsData   = inWord[HDR_KIND_BIT];
  assign stat.hdrStall    = inWord[HDR_STALL_BIT];
  assign stat.hdrReserved = hdrType[HDR_TYPE_W-1];
  assign stat.hdrEmpty    = inWord[HDR_KIND_BIT] ? (inWord[COUNT_W-1:0] == '0)
                                                 : (inWord[MASK_W-1:0] == '0);

  // lowest pending mask bit picks the next register slot
  assign lowOne = maskLeft & (~maskLeft + 1'b1);
  assign stat.regLast  = ((maskLeft & ~lowOne) == '0);
  assign stat.dataLast = (cntLeft == COUNT_W'(1));

  always_comb begin
    regWrIdx = '0;
    for (int i = 0; i < MASK_W; i++)
      if (lowOne[i]) regWrIdx = IDX_W'(i);
  end

  assign dataDest = typeReg[1:0];
  assign wrapNow  = strb.loadHdr ? inWord[HDR_WRAP_BIT] : wrapFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskLeft <= '0;
      cntLeft  <= '0;
      typeReg  <= '0;
      wrapFlag <= 1'b0;
      dataSeq  <= '0;
    end else begin
      if (strb.loadHdr) begin
        maskLeft <= inWord[MASK_W-1:0];
        cntLeft  <= inWord[COUNT_W-1:0];
        typeReg  <= hdrType;
        wrapFlag <= inWord[HDR_WRAP_BIT];
        dataSeq  <= '0;
      end
      if (strb.consumeReg) maskLeft <= maskLeft & ~lowOne;
      if (strb.consumeData) begin
        cntLeft <= cntLeft - 1'b1;
        dataSeq <= dataSeq + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPtr <= '0;
    else if (strb.accept) rdPtr <= (strb.endPkt && wrapNow) ? '0 : rdPtr + 1'b1;
  end

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && strb.endPkt && wrapNow) |=> (rdPtr == '0));
  assert_ptr_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.accept && !(strb.endPkt && wrapNow)) |=> (rdPtr == $past(rdPtr) + 1'b1));
  assert_idx_live_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.consumeReg |-> maskLeft[regWrIdx]);
  assert_mask_shrinks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.consumeReg && !strb.loadHdr) |=> ($countones(maskLeft) + 1 == $countones($past(maskLeft))));
endmodule

// File: rtl/cmdParserCtrl.sv
module cmdParserCtrl
  import cmdParserPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      pipeIdle,
  input  pathStat_t stat,
  output logic      inReady,
  output logic      regWrValid,
  output logic      dataValid,
  output logic      errReserved,
  output ctrlStrb_t strb
);
  parseState_t state, stateNext, pend, pendNext;

  always_comb begin
    parseState_t payload;
    parseState_t target;
    strb        = '0;
    inReady     = 1'b0;
    regWrValid  = 1'b0;
    dataValid   = 1'b0;
    errReserved = 1'b0;
    stateNext   = state;
    pendNext    = pend;
    payload     = ST_HDR;
    target      = ST_HDR;
    case (state)
      ST_HDR: begin
        inReady = 1'b1;
        if (inValid) begin
          strb.accept  = 1'b1;
          strb.loadHdr = 1'b1;
          strb.endPkt  = stat.hdrEmpty;
          errReserved  = stat.hdrIsData && stat.hdrReserved;
          if (!stat.hdrIsData)      payload = ST_REGS;
          else if (stat.hdrReserved) payload = ST_SKIP;
          else                       payload = ST_DATA;
          target = stat.hdrEmpty ? ST_HDR : payload;
          if (stat.hdrStall) begin
            stateNext = ST_WAIT;
            pendNext  = target;
          end else begin
            stateNext = target;
          end
        end
      end
      ST_WAIT: begin
        if (pipeIdle) stateNext = pend;
      end
      ST_REGS: begin
        inReady    = 1'b1;
        regWrValid = inValid;
        if (inValid) begin
          strb.accept     = 1'b1;
          strb.consumeReg = 1'b1;
          if (stat.regLast) begin
            strb.endPkt = 1'b1;
            stateNext   = ST_HDR;
          end
        end
      end
      ST_DATA, ST_SKIP: begin
        inReady   = 1'b1;
        dataValid = inValid && (state == ST_DATA);
        if (inValid) begin
          strb.accept      = 1'b1;
          strb.consumeData = 1'b1;
          if (stat.dataLast) begin
            strb.endPkt = 1'b1;
            stateNext   = ST_HDR;
          end
        end
      end
      default: stateNext = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HDR;
      pend  <= ST_HDR;
    end else begin
      state <= stateNext;
      pend  <= pendNext;
    end
  end

  assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !pipeIdle) |-> !inReady);
  assert_skip_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> (!dataValid && !regWrValid));
  assert_one_sink_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrValid && dataValid));
  assert_valid_needs_input_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrValid || dataValid) |-> inValid);
endmodule

// File: rtl/cmdParser.sv
module cmdParser
  import cmdParserPkg::*;
#(
  parameter int MASK_W  = 16,
  parameter int COUNT_W = 12,
  parameter int PTR_W   = 10,
  localparam int IDX_W  = (MASK_W > 1) ? $clog2(MASK_W) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        inWord,
  input  logic               inValid,
  output logic               inReady,
  input  logic               pipeIdle,
  output logic               regWrValid,
  output logic [IDX_W-1:0]   regWrIdx,
  output logic [31:0]        regWrData,
  output logic               dataValid,
  output logic [1:0]         dataDest,
  output logic [COUNT_W-1:0] dataSeq,
  output logic [31:0]        dataWord,
  output logic               errReserved,
  output logic [PTR_W-1:0]   rdPtr
);
  ctrlStrb_t strb;
  pathStat_t stat;

  cmdParserCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pipeIdle(pipeIdle),
    .stat(stat), .inReady(inReady), .regWrValid(regWrValid),
    .dataValid(dataValid), .errReserved(errReserved), .strb(strb)
  );

  cmdParserPath #(.MASK_W(MASK_W), .COUNT_W(COUNT_W), .PTR_W(PTR_W)) u_path (
    .clk(clk), .rstN(rstN), .inWord(inWord), .strb(strb), .stat(stat),
    .regWrIdx(regWrIdx), .dataDest(dataDest), .dataSeq(dataSeq), .rdPtr(rdPtr)
  );

  assign regWrData = inWord;
  assign dataWord  = inWord;
endmodule

// File: tb/cmdParser_bench.sv
module cmdParser_bench;
  localparam int MW = 6;
  localparam int CW = 4;
  localparam int PW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] inWord = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic pipeIdle = 1'b1;
  logic regWrValid;
  logic [2:0] regWrIdx;
  logic [31:0] regWrData;
  logic dataValid;
  logic [1:0] dataDest;
  logic [CW-1:0] dataSeq;
  logic [31:0] dataWord;
  logic errReserved;
  logic [PW-1:0] rdPtr;

  int checks = 0;
  int failures = 0;
  logic [PW-1:0] expPtr = '0;

  logic obsRegV, obsDataV, obsErr;
  logic [2:0] obsIdx;
  logic [31:0] obsRegD, obsDataW;
  logic [1:0] obsDest;
  logic [CW-1:0] obsSeq;

  always #5 clk = ~clk;

  cmdParser #(.MASK_W(MW), .COUNT_W(CW), .PTR_W(PW)) u_cmdParser (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid), .inReady(inReady),
    .pipeIdle(pipeIdle), .regWrValid(regWrValid), .regWrIdx(regWrIdx),
    .regWrData(regWrData), .dataValid(dataValid), .dataDest(dataDest),
    .dataSeq(dataSeq), .dataWord(dataWord), .errReserved(errReserved), .rdPtr(rdPtr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkReg(input int mask, input bit wrap, input bit stall);
    logic [31:0] w = '0;
    w[30] = wrap; w[29] = stall; w[MW-1:0] = mask[MW-1:0];
    return w;
  endfunction

  function automatic logic [31:0] mkData(input int t, input int c, input bit wrap, input bit stall);
    logic [31:0] w = '0;
    w[31] = 1'b1; w[30] = wrap; w[29] = stall; w[28:26] = t[2:0]; w[CW-1:0] = c[CW-1:0];
    return w;
  endfunction

  // starts and ends at a falling edge; outputs captured in the accept cycle
  task automatic putWord(input logic [31:0] w);
    inWord = w; inValid = 1'b1;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    obsRegV = regWrValid; obsIdx = regWrIdx; obsRegD = regWrData;
    obsDataV = dataValid; obsDest = dataDest; obsSeq = dataSeq;
    obsDataW = dataWord; obsErr = errReserved;
    @(posedge clk); #1;
    inValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic stepPtr(input bit wrapEnd, input string req);
    expPtr = wrapEnd ? '0 : expPtr + 1'b1;
    check(rdPtr == expPtr, req, rdPtr, expPtr);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R9 reset state
    check(inReady == 1'b1, "R9 inReady", inReady, 1);
    check(rdPtr == '0, "R9 rdPtr", rdPtr, 0);
    check(!regWrValid && !dataValid && !errReserved, "R9 strobes", {regWrValid, dataValid, errReserved}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R2: every mask value
    for (int m = 0; m < (1 << MW); m++) begin
      bit wr;
      int left;
      wr = (m % 5 == 0);
      left = $countones(m[MW-1:0]);
      putWord(mkReg(m, wr, (m % 9 == 0)));
      check(!obsRegV && !obsDataV && !obsErr, "R2 header silent", obsRegV, 0);
      stepPtr(wr && left == 0, "R8 empty mask pointer");
      for (int i = 0; i < MW; i++) begin
        if (m[i]) begin
          logic [31:0] d;
          d = 32'hC0DE_0000 | (m << 8) | i;
          putWord(d);
          left--;
          check(obsRegV && obsIdx == i[2:0] && obsRegD == d, "R1 register slot", obsIdx, i);
          check(!obsDataV, "R10 no data on register write", obsDataV, 0);
          stepPtr(wr && left == 0, "R7 R8 pointer after write");
        end
      end
      // R2: next word must be taken as a header (empty data packet, silent)
      putWord(mkData(1, 0, 1'b0, 1'b0));
      check(!obsRegV && !obsDataV, "R2 next word is header", obsRegV, 0);
      stepPtr(1'b0, "R7 pointer after header");
    end

    // R3 R4 R5: every type and small counts
    for (int t = 0; t < 8; t++) begin
      for (int c = 0; c < 6; c++) begin
        bit wr;
        wr = (c == 3) || (c == 0 && t == 5);
        putWord(mkData(t, c, wr, 1'b0));
        check(obsErr == (t >= 4), "R5 error strobe on header", obsErr, t >= 4);
        check(!obsRegV && !obsDataV, "R4 header silent", obsDataV, 0);
        stepPtr(wr && c == 0, "R8 empty data pointer");
        for (int k = 0; k < c; k++) begin
          logic [31:0] d;
          d = 32'h5A00_0000 | (t << 12) | (c << 4) | k;
          putWord(d);
          if (t < 4) begin
            check(obsDataV && obsDest == t[1:0] && obsSeq == k[CW-1:0] && obsDataW == d,
                  "R3 data word routing", {obsDest, obsSeq}, {t[1:0], k[CW-1:0]});
          end else begin
            check(!obsDataV && !obsRegV && !obsErr, "R5 reserved payload silent", obsDataV, 0);
          end
          stepPtr(wr && k == c - 1, "R7 R8 data pointer");
        end
        // R4: a register header with one bit must parse as a header next
        putWord(mkReg(2, 1'b0, 1'b0));
        check(!obsRegV && !obsDataV, "R4 header after packet", obsRegV, 0);
        stepPtr(1'b0, "R7 pointer");
        putWord(32'h1111_0000 | (t << 4) | c);
        check(obsRegV && obsIdx == 3'd1, "R4 resync register write", obsIdx, 1);
        stepPtr(1'b0, "R7 pointer");
      end
    end

    // R6: stall holds the payload while the pipeline is busy
    pipeIdle = 1'b0;
    putWord(mkReg(1, 1'b0, 1'b0));
    stepPtr(1'b0, "R6 non-stall header pointer");
    putWord(32'h0000_BEEF);
    check(obsRegV && obsIdx == 3'd0, "R6 non-stall proceeds while busy", obsRegV, 1);
    stepPtr(1'b0, "R7 pointer");
    putWord(mkData(1, 2, 1'b1, 1'b1));
    stepPtr(1'b0, "R6 stall header pointer");
    inWord = 32'h7777_0001; inValid = 1'b1;
    for (int n = 0; n < 5; n++) begin
      #1;
      check(inReady == 1'b0, "R6 stalled while busy", inReady, 0);
      check(!dataValid, "R6 no output while stalled", dataValid, 0);
      @(negedge clk);
    end
    check(rdPtr == expPtr, "R6 pointer frozen", rdPtr, expPtr);
    pipeIdle = 1'b1;
    putWord(32'h7777_0001);
    check(obsDataV && obsDest == 2'd1 && obsSeq == 0, "R6 payload after idle", obsDataV, 1);
    stepPtr(1'b0, "R7 pointer");
    putWord(32'h7777_0002);
    check(obsDataV && obsSeq == 1, "R6 second payload", obsSeq, 1);
    stepPtr(1'b1, "R8 wrap after stall packet");

    // R10 / R9: idle input yields no strobes
    #1;
    check(!regWrValid && !dataValid, "R10 no strobe without input", {regWrValid, dataValid}, 0);

    disable watchdog;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule